// File: doc/BRIEF.md
# Upper-Memory Shadow Router

This block decides where each CPU memory cycle is served. Cycles in the 640K to 1M window land in one of four places: a read from local DRAM, a write into local DRAM, a cycle passed to the expansion (AT) bus, or a write that is thrown away. The decision depends on a set of configuration registers. The ROM segments from C0000h to EFFFFh are enabled in 16KB blocks. A 64KB master enable covers each segment. Reads from an enabled block come from DRAM, and writes follow a copy control and a per-segment write protect. The top 64KB BIOS segment has its own two-mode control and a small unprotect window.

When the D and E segments carry no shadow copy, the block can relocate two 128KB windows of local DRAM (A0000h and D0000h) so that they appear at a programmable megabyte boundary above 1MB. Cycles that hit the relocated range get a translated DRAM address.

Software reaches the configuration registers through two I/O ports. It writes a register number to the index port and then does one read or write at the data port. Each data access uses up the index. The routing decision and DRAM address come out registered, one clock after the cycle is presented.

Top module: `shadow_route_top`

## Requirements
- R1: A write to I/O port 22h stores a register number, and a read of port 22h returns the last number written. One read or write at port 24h then accesses that register, after which the index is invalid. A port 24h read with no valid index returns FFh, and a port 24h write with no valid index changes nothing.
- R2: After reset, register 11h reads F0h and registers 12h, 13h and 14h read 00h. Register 14h keeps only bit 7, and its other bits always read 0. Any other register number reads 00h and ignores writes.
- R3: A memory cycle presented with mem_valid is answered on the next clock with out_valid high and out_route coded as follows: 0 = AT bus, 1 = DRAM read, 2 = DRAM write, 3 = dropped write.
- R4: In F0000h–FFFFFh, when register 11h bit 7 is 1, reads go to the bus and writes to DRAM. When bit 7 is 0, reads come from DRAM and writes are dropped.
- R5: When register 11h bit 7 is 0 and register 14h bit 7 is 1, writes to F0000h–F0FFFh go to DRAM. Writes elsewhere in the F segment are still dropped.
- R6: Register 11h bits 4, 5 and 6 are master enables for the C, D and E segments. When a segment's bit is 0, every cycle to that segment goes to the bus.
- R7: Register 13h bits 4..7 enable blocks C0000h, C4000h, C8000h and CC000h. Register 12h bits 0..7 enable blocks D0000h through EC000h in ascending order. A read of an enabled block (with its segment master on) comes from DRAM. Any cycle to a block that is not enabled goes to the bus.
- R8: A write to an enabled, unprotected block goes to DRAM when register 11h bit 3 is 1, and to the bus when it is 0.
- R9: Register 11h bits 0, 1 and 2 write-protect the C, D and E segments. A write to an enabled block of a protected segment is dropped, whatever the copy control says.
- R10: A0000h–BFFFFh always routes to the bus. Addresses below A0000h, and addresses at or above 1MB outside the relocated range, route to DRAM with dram_addr equal to the cycle address.
- R11: Relocation is active when register 13h bits 3:0 (base in MB) are nonzero and no D or E block is enabled with its master on. While it is active, base+0..base+1FFFFh maps to DRAM address A0000h+offset, and base+20000h..base+3FFFFh maps to D0000h+offset.
- R12: A configuration write affects memory cycles presented from the following clock onward. A cycle presented in the same clock uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, valid in the same cycle as io_rd |
| mem_valid | input | 1 | Memory cycle present |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 24 | Memory cycle byte address |
| out_valid | output | 1 | Routing result valid |
| out_route | output | 2 | Routing outcome code |
| dram_addr | output | 24 | Translated local DRAM address |

## Verification
I/O read data is combinational, so the bench samples io_rdata in the same cycle as the read strobe. It does this before the edge that invalidates the index. The routing result and the DRAM address arrive exactly one clock after the cycle is presented, so the bench drives each cycle on a falling edge and compares at the next falling edge. A directed test presents a configuration write and a memory cycle in the same clock. It expects the old settings in that cycle's result and the new settings in the result of the following cycle.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

    typedef enum logic [1:0] {
        ROUTE_BUS     = 2'd0,
        ROUTE_DRAM_RD = 2'd1,
        ROUTE_DRAM_WR = 2'd2,
        ROUTE_DROP    = 2'd3
    } route_e;

    localparam logic [7:0] REG_SEG_CTL  = 8'h11;
    localparam logic [7:0] REG_BLK_DE   = 8'h12;
    localparam logic [7:0] REG_BLK_C_RB = 8'h13;
    localparam logic [7:0] REG_MISC     = 8'h14;

    localparam logic [7:0] SEG_CTL_RST  = 8'hF0;
    localparam logic [7:0] NO_INDEX_VAL = 8'hFF;

    typedef struct packed {
        logic [7:0] seg_ctl;    // bios mode, masters, copy, protects
        logic [7:0] blk_de;     // D/E block enables
        logic [7:0] blk_c_rb;   // C block enables and relocation base
        logic       f_unlock;   // low-4KB unprotect
    } shadow_cfg_t;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_route_pkg::*;
#(
    parameter int          IO_AW     = 8,
    parameter logic [7:0]  IDX_PORT  = 8'h22,
    parameter logic [7:0]  DATA_PORT = 8'h24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output shadow_cfg_t      cfg
);

    typedef struct packed {
        logic [7:0]  idx;
        logic        idx_vld;
        shadow_cfg_t regs;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       hit_idx, hit_dat;

    assign hit_idx = (io_addr == IO_AW'(IDX_PORT));
    assign hit_dat = (io_addr == IO_AW'(DATA_PORT));

    always_comb begin
        st_d     = st_q;
        io_rdata = 8'h00;
        if (io_rd && hit_idx) begin
            io_rdata = st_q.idx;
        end
        if (io_rd && hit_dat) begin
            if (!st_q.idx_vld) begin
                io_rdata = NO_INDEX_VAL;
            end else begin
                case (st_q.idx)
                    REG_SEG_CTL:  io_rdata = st_q.regs.seg_ctl;
                    REG_BLK_DE:   io_rdata = st_q.regs.blk_de;
                    REG_BLK_C_RB: io_rdata = st_q.regs.blk_c_rb;
                    REG_MISC:     io_rdata = {st_q.regs.f_unlock, 7'b0};
                    default:      io_rdata = 8'h00;
                endcase
            end
        end
        if (io_wr && hit_idx) begin
            st_d.idx     = io_wdata;
            st_d.idx_vld = 1'b1;
        end
        if ((io_wr || io_rd) && hit_dat) begin
            st_d.idx_vld = 1'b0;
            if (io_wr && st_q.idx_vld) begin
                case (st_q.idx)
                    REG_SEG_CTL:  st_d.regs.seg_ctl  = io_wdata;
                    REG_BLK_DE:   st_d.regs.blk_de   = io_wdata;
                    REG_BLK_C_RB: st_d.regs.blk_c_rb = io_wdata;
                    REG_MISC:     st_d.regs.f_unlock = io_wdata[7];
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx           <= 8'h00;
            st_q.idx_vld       <= 1'b0;
            st_q.regs.seg_ctl  <= SEG_CTL_RST;
            st_q.regs.blk_de   <= 8'h00;
            st_q.regs.blk_c_rb <= 8'h00;
            st_q.regs.f_unlock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.regs;

    // R1
    idx_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && hit_dat && !(io_wr && hit_idx)) |=> !st_q.idx_vld);

    // R1
    idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_idx) |=> (st_q.idx_vld && st_q.idx == $past(io_wdata)));

endmodule

// File: rtl/shadow_remap_xlate.sv
module shadow_remap_xlate #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        base_mb,
    input  logic              de_used,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    localparam int MB_SHIFT = 20;
    localparam int TOP_W    = ADDR_W - MB_SHIFT;
    localparam int WIN_W    = 17;
    localparam logic [ADDR_W-1:0] LOW_WIN  = ADDR_W'(24'h0A0000);
    localparam logic [ADDR_W-1:0] HIGH_WIN = ADDR_W'(24'h0D0000);

    logic active;

    assign active = (base_mb != 4'd0) && !de_used;
    assign hit    = active
                 && (addr[ADDR_W-1:MB_SHIFT] == TOP_W'(base_mb))
                 && (addr[MB_SHIFT-1:WIN_W+1] == '0);

    always_comb begin
        if (addr[WIN_W]) begin
            xaddr = HIGH_WIN + ADDR_W'(addr[WIN_W-1:0]);
        end else begin
            xaddr = LOW_WIN + ADDR_W'(addr[WIN_W-1:0]);
        end
    end

endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
    import shadow_route_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int SEGS         = 3,
    parameter int BLKS_PER_SEG = 4
) (
    input  shadow_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output route_e            route,
    output logic [ADDR_W-1:0] xaddr
);

    localparam int NBLK = SEGS * BLKS_PER_SEG;

    logic [NBLK-1:0] blk_bits;
    logic [NBLK-1:0] blk_en;
    logic [15:0]     blk_en_pad;
    logic [3:0]      bidx;
    logic [3:0]      seg;
    logic            above_1m;
    logic            de_used;
    logic            rm_hit;
    logic [ADDR_W-1:0] rm_addr;
    route_e          local_route;

    assign blk_bits = {cfg.blk_de, cfg.blk_c_rb[7:4]};

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign blk_en[g] = blk_bits[g] & cfg.seg_ctl[4 + g / BLKS_PER_SEG];
    end

    assign blk_en_pad  = 16'(blk_en);
    assign de_used     = |blk_en[NBLK-1:BLKS_PER_SEG];
    assign seg         = addr[19:16];
    assign bidx        = {seg[1:0], addr[15:14]};
    assign above_1m    = |addr[ADDR_W-1:20];
    assign local_route = write ? ROUTE_DRAM_WR : ROUTE_DRAM_RD;

    shadow_remap_xlate #(.ADDR_W(ADDR_W)) u_remap (
        .addr    (addr),
        .base_mb (cfg.blk_c_rb[3:0]),
        .de_used (de_used),
        .hit     (rm_hit),
        .xaddr   (rm_addr)
    );

    always_comb begin
        route = local_route;
        xaddr = addr;
        if (above_1m) begin
            if (rm_hit) begin
                xaddr = rm_addr;
            end
        end else begin
            case (seg)
                4'hA, 4'hB: route = ROUTE_BUS;
                4'hF: begin
                    if (cfg.seg_ctl[7]) begin
                        route = write ? ROUTE_DRAM_WR : ROUTE_BUS;
                    end else if (!write) begin
                        route = ROUTE_DRAM_RD;
                    end else if (cfg.f_unlock && addr[15:12] == 4'h0) begin
                        route = ROUTE_DRAM_WR;
                    end else begin
                        route = ROUTE_DROP;
                    end
                end
                4'hC, 4'hD, 4'hE: begin
                    if (!blk_en_pad[bidx]) begin
                        route = ROUTE_BUS;
                    end else if (!write) begin
                        route = ROUTE_DRAM_RD;
                    end else if (cfg.seg_ctl[seg[1:0]]) begin
                        route = ROUTE_DROP;
                    end else if (cfg.seg_ctl[3]) begin
                        route = ROUTE_DRAM_WR;
                    end else begin
                        route = ROUTE_BUS;
                    end
                end
                default: route = local_route;
            endcase
        end
    end

endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
    import shadow_route_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          IO_AW     = 8,
    parameter logic [7:0]  IDX_PORT  = 8'h22,
    parameter logic [7:0]  DATA_PORT = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              out_valid,
    output logic [1:0]        out_route,
    output logic [ADDR_W-1:0] dram_addr
);

    typedef struct packed {
        logic              vld;
        route_e            route;
        logic [ADDR_W-1:0] addr;
    } out_state_t;

    shadow_cfg_t       cfg;
    route_e            dec_route;
    logic [ADDR_W-1:0] dec_addr;
    out_state_t        out_d, out_q;

    shadow_cfg_regs #(
        .IO_AW     (IO_AW),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cfg      (cfg)
    );

    shadow_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cfg   (cfg),
        .addr  (mem_addr),
        .write (mem_write),
        .route (dec_route),
        .xaddr (dec_addr)
    );

    always_comb begin
        out_d       = out_q;
        out_d.vld   = mem_valid;
        if (mem_valid) begin
            out_d.route = dec_route;
            out_d.addr  = dec_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.vld   <= 1'b0;
            out_q.route <= ROUTE_BUS;
            out_q.addr  <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_route = out_q.route;
    assign dram_addr = out_q.addr;

    // R3
    result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_valid));

    // R3
    drop_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_route == 2'd3) |-> $past(mem_write));

    // R3
    dram_rd_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_route == 2'd1) |-> !$past(mem_write));

    // R10
    ab_window_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mem_addr[ADDR_W-1:17]) == 7'h05) |-> out_route == 2'd0);

    // R11
    xlate_above_1m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dram_addr != $past(mem_addr)) |-> ($past(mem_addr[ADDR_W-1:20]) != '0));

endmodule

// File: tb/tb_shadow_route_top.sv
module tb_shadow_route_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        mem_valid = 1'b0, mem_write = 1'b0;
    logic [23:0] mem_addr = 24'h0;
    logic        out_valid;
    logic [1:0]  out_route;
    logic [23:0] dram_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] m11 = 8'hF0, m12 = 8'h00, m13 = 8'h00, m14 = 8'h00;

    shadow_route_top dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .out_valid(out_valid), .out_route(out_route), .dram_addr(dram_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] ref_out(input logic [23:0] a, input logic w);
        logic [1:0]  r;
        logic [23:0] d;
        logic [11:0] be;
        logic [3:0]  bi;
        logic        on;
        logic [1:0]  s;
        r  = w ? 2'd2 : 2'd1;
        d  = a;
        be = {m12, m13[7:4]} & {{4{m11[6]}}, {4{m11[5]}}, {4{m11[4]}}};
        on = (m13[3:0] != 4'd0) && (be[11:4] == 8'd0);
        if (a[23:20] != 4'd0) begin
            if (on && a[23:20] == m13[3:0] && a[19:18] == 2'b00)
                d = (a[17] ? 24'h0D0000 : 24'h0A0000) + {7'd0, a[16:0]};
        end else begin
            case (a[19:16])
                4'hA, 4'hB: r = 2'd0;
                4'hF: begin
                    if (m11[7]) r = w ? 2'd2 : 2'd0;
                    else if (!w) r = 2'd1;
                    else r = (m14[7] && a[15:12] == 4'h0) ? 2'd2 : 2'd3;
                end
                4'hC, 4'hD, 4'hE: begin
                    s  = a[17:16];
                    bi = {s, a[15:14]};
                    if (!be[bi]) r = 2'd0;
                    else if (!w) r = 2'd1;
                    else if (m11[s]) r = 2'd3;
                    else r = m11[3] ? 2'd2 : 2'd0;
                end
                default: ;
            endcase
        end
        return {r, d};
    endfunction

    task automatic io_write(input logic [7:0] port, input logic [7:0] d);
        io_addr = port; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read_chk(input logic [7:0] port, input logic [7:0] exp, input string tag);
        io_addr = port; io_rd = 1'b1;
        #1;
        chk(io_rdata == exp, tag, {24'd0, io_rdata}, {24'd0, exp});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic model_set(input logic [7:0] idx, input logic [7:0] d);
        case (idx)
            8'h11: m11 = d;
            8'h12: m12 = d;
            8'h13: m13 = d;
            8'h14: m14 = {d[7], 7'd0};
            default: ;
        endcase
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(8'h22, idx);
        io_write(8'h24, d);
        model_set(idx, d);
    endtask

    task automatic cfg_read_chk(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        io_write(8'h22, idx);
        io_read_chk(8'h24, exp, tag);
    endtask

    task automatic mem_chk(input logic [23:0] a, input logic w, input string tag);
        logic [25:0] e;
        e = ref_out(a, w);
        mem_valid = 1'b1; mem_addr = a; mem_write = w;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(out_route == e[25:24], {tag, " route"}, {30'd0, out_route}, {30'd0, e[25:24]});
        chk(dram_addr == e[23:0], {tag, " addr"}, {8'd0, dram_addr}, {8'd0, e[23:0]});
    endtask

    function automatic logic [23:0] rand_addr();
        logic [31:0] r;
        int          c;
        r = $urandom;
        c = $urandom % 6;
        case (c)
            0: return {4'h0, 2'b11, r[17:0]};
            1: return {4'h0, 3'b101, r[16:0]};
            2: return {4'h0, 4'h0 + 4'(r[19:16] % 10), r[15:0]};
            3: return {m13[3:0], 2'b00, r[17:0]};
            4: return {4'h0, 4'hF, 4'h0, r[11:0]};
            default: return r[23:0];
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk(out_valid == 1'b0, "R2 out_valid after reset", {31'd0, out_valid}, 32'd0);
        cfg_read_chk(8'h11, 8'hF0, "R2 reg11 reset");
        cfg_read_chk(8'h12, 8'h00, "R2 reg12 reset");
        cfg_read_chk(8'h13, 8'h00, "R2 reg13 reset");
        cfg_read_chk(8'h14, 8'h00, "R2 reg14 reset");
        cfg_read_chk(8'h10, 8'h00, "R2 unknown index reads zero");

        // R1 index readback, invalidation, ignored write
        io_write(8'h22, 8'h12);
        io_read_chk(8'h22, 8'h12, "R1 index readback");
        io_read_chk(8'h24, 8'h00, "R1 data read with index");
        io_read_chk(8'h24, 8'hFF, "R1 no index reads FF");
        io_write(8'h24, 8'h5A);
        cfg_read_chk(8'h12, 8'h00, "R1 write without index ignored");
        cfg_write(8'h14, 8'hFF);
        cfg_read_chk(8'h14, 8'h80, "R2 reg14 reserved bits zero");
        cfg_write(8'h14, 8'h00);

        // R4 bios mode default
        mem_chk(24'h0F8000, 1'b0, "R4 F read bus");
        mem_chk(24'h0F8000, 1'b1, "R4 F write dram");
        // R12 same-cycle config write uses old setting
        io_write(8'h22, 8'h11);
        io_addr = 8'h24; io_wdata = 8'h70; io_wr = 1'b1;
        mem_valid = 1'b1; mem_addr = 24'h0F4000; mem_write = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; mem_valid = 1'b0;
        chk(out_route == 2'd2, "R12 same cycle old setting", {30'd0, out_route}, 32'd2);
        model_set(8'h11, 8'h70);
        mem_chk(24'h0F4000, 1'b1, "R12 next cycle new setting");
        mem_chk(24'h0F4000, 1'b0, "R4 F read dram");
        // R5 unprotect window
        cfg_write(8'h14, 8'h80);
        mem_chk(24'h0F0123, 1'b1, "R5 unlock low 4KB");
        mem_chk(24'h0F1000, 1'b1, "R5 beyond window dropped");
        // R6 R7 R8 R9
        cfg_write(8'h13, 8'h10);
        mem_chk(24'h0C0100, 1'b0, "R7 enabled C block read");
        mem_chk(24'h0C4100, 1'b0, "R7 disabled C block bus");
        mem_chk(24'h0C0100, 1'b1, "R8 copy off write bus");
        cfg_write(8'h11, 8'h78);
        mem_chk(24'h0C0100, 1'b1, "R8 copy on write dram");
        cfg_write(8'h11, 8'h79);
        mem_chk(24'h0C0100, 1'b1, "R9 protect drops write");
        mem_chk(24'h0C0100, 1'b0, "R9 protect read dram");
        cfg_write(8'h11, 8'h69);
        mem_chk(24'h0C0100, 1'b0, "R6 C master off bus");
        cfg_write(8'h12, 8'h80);
        mem_chk(24'h0EC000, 1'b0, "R7 top E block read");
        // R10
        mem_chk(24'h0A1234, 1'b0, "R10 A window bus");
        mem_chk(24'h012345, 1'b1, "R10 low memory local");
        // R11 relocation blocked while E shadow used, then active
        cfg_write(8'h13, 8'h03);
        mem_chk(24'h300010, 1'b0, "R11 blocked by E shadow");
        cfg_write(8'h12, 8'h00);
        mem_chk(24'h300010, 1'b0, "R11 low window");
        mem_chk(24'h320010, 1'b1, "R11 high window");
        mem_chk(24'h340000, 1'b0, "R11 past relocated range");

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0) begin
                cfg_write(8'h11, 8'($urandom));
                cfg_write(8'h12, ($urandom % 2 == 0) ? 8'h00 : 8'($urandom));
                cfg_write(8'h13, 8'($urandom));
                cfg_write(8'h14, 8'($urandom));
            end
            mem_chk(rand_addr(), 1'($urandom), "R3 random routing");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule